// File: doc/BRIEF.md
# Serial Codec Control Word Receiver

This block takes 16-bit words that a host sends over a framed synchronous serial link and turns each one into parallel results in the system clock domain. The link has three lines: a shift clock, an active-low frame sync and serial data. All three are synchronized into the system clock, and data bits are taken on each rising shift-clock edge, starting with the most significant bit. The system clock must run several times faster than the shift clock.

A primary word carries two things. Its upper fourteen bits are a sample for the output converter. Its two lowest bits are an in-band command for the converter timing generator. That command can ask for a normal period, a longer period or a shorter period, or it can announce a secondary control word. When a secondary word is announced, the host keeps the frame sync high for four shift-clock edges and then frames the secondary word with the same bit timing. The block captures that word whole and presents it on a port of its own. This places the secondary word between two primary words, so no converter sample is lost.

Top module: `scw_rx`

## Requirements
- R1: A word starts on a rising shift-clock edge at which the synchronized frame sync is low. The data bit taken on that edge is bit 15, and the next fifteen rising edges supply bits 14 down to 0 in that order.
- R2: When a primary word completes, `sample_o` takes bits 15..2 of the word, and `sample_vld_o` is high for exactly one system clock.
- R3: When a primary word completes, `cmd_o` takes bits 1..0 of the word, and `cmd_vld_o` pulses in the same cycle as `sample_vld_o`. The codes are 00 for a normal period, 01 for a lengthened period, 10 for a shortened period and 11 for a secondary word to follow.
- R4: After a primary word with code 11, the next four rising shift-clock edges are ignored whatever the frame sync level. The first later edge with frame sync low starts the secondary word.
- R5: A completed secondary word appears whole on `sec_word_o`, and `sec_vld_o` pulses for one cycle. `sample_o` and `cmd_o` keep their values, and neither `sample_vld_o` nor `cmd_vld_o` pulses.
- R6: After a primary word with code 00, 01 or 10, the next framed word is treated as a primary word.
- R7: While bits 14..0 of a word are being shifted in, the frame sync level has no effect on the captured word.
- R8: Reset clears all outputs to zero, clears the shift register and the bit counter, and leaves the block waiting for a primary word. A word that was partly received or a secondary word that was pending is dropped.
- R9: No strobe stays high for two cycles in a row, and `sample_vld_o` and `sec_vld_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| fsync_n_i | input | 1 | Active-low frame sync (asynchronous) |
| sdata_i | input | 1 | Serial data, most significant bit first |
| sample_o | output | 14 | Converter sample from the last primary word |
| sample_vld_o | output | 1 | One-cycle strobe for a new sample |
| cmd_o | output | 2 | Period-adjust command from the last primary word |
| cmd_vld_o | output | 1 | One-cycle strobe for a new command |
| sec_word_o | output | 16 | Last secondary control word |
| sec_vld_o | output | 1 | One-cycle strobe for a new secondary word |

## Verification
Two things can land on the same shift-clock edge: the end of the four-edge gap and a low frame sync that would start a word. The bench provokes this by holding the frame sync low on every gap edge, and at random on other runs, before it frames the secondary word. A correct design captures a secondary word equal to the one sent. If the gap ends too early, the captured word is shifted by one or more bits, or a wrong strobe fires. The bench also resets the block in the middle of a word and in the armed state, then checks that the next word is read as a primary word.

// File: rtl/scw_pkg.sv
package scw_pkg;

    localparam int WORD_W   = 16;
    localparam int CODE_W   = 2;
    localparam int SAMPLE_W = WORD_W - CODE_W;

    typedef enum logic [CODE_W-1:0] {
        CMD_NORMAL    = 2'b00,
        CMD_LENGTHEN  = 2'b01,
        CMD_SHORTEN   = 2'b10,
        CMD_SECONDARY = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRIM,
        ST_GAP,
        ST_ARM,
        ST_SEC
    } frame_st_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] sample;
        cmd_e                cmd;
    } prim_word_t;

    function automatic prim_word_t split_word(input logic [WORD_W-1:0] w);
        prim_word_t p;
        p.sample = w[WORD_W-1:CODE_W];
        p.cmd    = cmd_e'(w[CODE_W-1:0]);
        return p;
    endfunction

endpackage

// File: rtl/scw_sync.sv
module scw_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] pipe [STAGES];

    // Reset to ones: frame sync reads idle and the shift clock reads high,
    // so no edge is seen when reset is released.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/scw_shifter.sv
module scw_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_i,
    input  logic         first_i,
    input  logic         bit_i,
    output logic [W-1:0] word_o,
    output logic         done_o
);
    localparam int CW = $clog2(W);

    logic [W-2:0]  shreg;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (cap_i) begin
            shreg <= {shreg[W-3:0], bit_i};
            cnt   <= first_i ? CW'(1) : cnt + CW'(1);
        end
    end

    assign word_o = {shreg, bit_i};
    assign done_o = cap_i && !first_i && (cnt == CW'(W - 1));
endmodule

// File: rtl/scw_ctrl.sv
module scw_ctrl
    import scw_pkg::*;
#(
    parameter int GAP_EDGES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_i,
    input  logic fs_n_i,
    input  logic done_i,
    input  logic code_sec_i,
    output logic cap_o,
    output logic first_o,
    output logic prim_done_o,
    output logic sec_done_o
);
    localparam int GW = $clog2(GAP_EDGES + 1);

    frame_st_e      st;
    logic [GW-1:0]  gap_cnt;

    always_comb begin
        cap_o   = 1'b0;
        first_o = 1'b0;
        if (edge_i) begin
            unique case (st)
                ST_IDLE, ST_ARM: begin
                    cap_o   = !fs_n_i;
                    first_o = !fs_n_i;
                end
                ST_PRIM, ST_SEC: cap_o = 1'b1;
                default: ;
            endcase
        end
    end

    assign prim_done_o = done_i && (st == ST_PRIM);
    assign sec_done_o  = done_i && (st == ST_SEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            gap_cnt <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (first_o) st <= ST_PRIM;
                ST_PRIM: if (done_i) begin
                    st      <= code_sec_i ? ST_GAP : ST_IDLE;
                    gap_cnt <= '0;
                end
                ST_GAP: if (edge_i) begin
                    if (gap_cnt == GW'(GAP_EDGES - 1)) st <= ST_ARM;
                    gap_cnt <= gap_cnt + GW'(1);
                end
                ST_ARM:  if (first_o) st <= ST_SEC;
                ST_SEC:  if (done_i) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_SEC_FROM_ARM: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SEC && $past(st) != ST_SEC) |-> $past(st) == ST_ARM); // R4
    AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_GAP) |=> (st == ST_GAP || st == ST_ARM)); // R4
    AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (st == ST_GAP) |-> gap_cnt < GW'(GAP_EDGES)); // R4
endmodule

// File: rtl/scw_rx.sv
module scw_rx
    import scw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int GAP_EDGES   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk_i,
    input  logic                fsync_n_i,
    input  logic                sdata_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                sample_vld_o,
    output logic [CODE_W-1:0]   cmd_o,
    output logic                cmd_vld_o,
    output logic [WORD_W-1:0]   sec_word_o,
    output logic                sec_vld_o
);
    logic [2:0]        sync_q;
    logic              sclk_s, fs_n_s, data_s, sclk_prev, rise;
    logic              cap, first, done, prim_done, sec_done;
    logic [WORD_W-1:0] word;
    prim_word_t        pw;

    scw_sync #(.STAGES(SYNC_STAGES), .W(3)) i_sync (
        .clk (clk),
        .rst (rst),
        .din ({sclk_i, fsync_n_i, sdata_i}),
        .dout(sync_q)
    );
    assign {sclk_s, fs_n_s, data_s} = sync_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b1;
        else     sclk_prev <= sclk_s;
    end
    assign rise = sclk_s && !sclk_prev;

    scw_shifter #(.W(WORD_W)) i_shifter (
        .clk    (clk),
        .rst    (rst),
        .cap_i  (cap),
        .first_i(first),
        .bit_i  (data_s),
        .word_o (word),
        .done_o (done)
    );

    assign pw = split_word(word);

    scw_ctrl #(.GAP_EDGES(GAP_EDGES)) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .edge_i     (rise),
        .fs_n_i     (fs_n_s),
        .done_i     (done),
        .code_sec_i (pw.cmd == CMD_SECONDARY),
        .cap_o      (cap),
        .first_o    (first),
        .prim_done_o(prim_done),
        .sec_done_o (sec_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_o     <= '0;
            cmd_o        <= '0;
            sec_word_o   <= '0;
            sample_vld_o <= 1'b0;
            cmd_vld_o    <= 1'b0;
            sec_vld_o    <= 1'b0;
        end else begin
            sample_vld_o <= prim_done;
            cmd_vld_o    <= prim_done;
            sec_vld_o    <= sec_done;
            if (prim_done) begin
                sample_o <= pw.sample;
                cmd_o    <= pw.cmd;
            end
            if (sec_done) sec_word_o <= word;
        end
    end

    AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        sample_vld_o |=> !sample_vld_o); // R9
    AST_SEC_PULSE: assert property (@(posedge clk) disable iff (rst)
        sec_vld_o |=> !sec_vld_o); // R9
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sample_vld_o, sec_vld_o})); // R9
    AST_SEC_KEEPS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        sec_vld_o |-> ($stable(sample_o) && $stable(cmd_o) && !cmd_vld_o)); // R5
    AST_CMD_WITH_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_vld_o) |-> sample_vld_o); // R3
endmodule

// File: tb/test_scw_rx.sv
module test_scw_rx;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b1, fs_n = 1'b1, sd = 1'b0;
    logic [13:0] sample_o;
    logic [1:0]  cmd_o;
    logic [15:0] sec_word_o;
    logic        sample_vld_o, cmd_vld_o, sec_vld_o;

    int checks = 0, fails = 0;
    int n_samp = 0, n_sec = 0, strobe_err = 0;
    logic [13:0] lat_sample;
    logic [1:0]  lat_cmd;
    logic [15:0] lat_sec;
    logic        prev_s = 1'b0, prev_x = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scw_rx i_scw_rx (
        .clk(clk), .rst(rst), .sclk_i(sclk), .fsync_n_i(fs_n), .sdata_i(sd),
        .sample_o(sample_o), .sample_vld_o(sample_vld_o), .cmd_o(cmd_o),
        .cmd_vld_o(cmd_vld_o), .sec_word_o(sec_word_o), .sec_vld_o(sec_vld_o)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (sample_vld_o) begin
                n_samp++; lat_sample = sample_o; lat_cmd = cmd_o;
                if (!cmd_vld_o) strobe_err++;
            end
            if (sec_vld_o) begin n_sec++; lat_sec = sec_word_o; end
            if (sample_vld_o && sec_vld_o) strobe_err++;
            if ((sample_vld_o && prev_s) || (sec_vld_o && prev_x)) strobe_err++;
        end
        prev_s = sample_vld_o;
        prev_x = sec_vld_o;
    end

    function automatic logic [13:0] exp_sample(input logic [15:0] w);
        return w[15:2];
    endfunction
    function automatic logic [1:0] exp_cmd(input logic [15:0] w);
        return w[1:0];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b, input logic fs);
        @(negedge clk);
        sclk = 1'b0; fs_n = fs; sd = b;
        repeat (HALF) @(negedge clk);
        sclk = 1'b1;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic send_word(input logic [15:0] w, input bit fs_release);
        for (int i = 15; i >= 0; i--)
            shift_bit(w[i], (i == 15) ? 1'b0 : (fs_release ? 1'b1 : 1'b0));
        fs_n = 1'b1;
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic gap(input int n, input int fs_mode);
        for (int i = 0; i < n; i++)
            shift_bit(1'($urandom), (fs_mode == 0) ? 1'b1 : (fs_mode == 1) ? 1'b0 : 1'($urandom));
    endtask

    task automatic do_primary(input logic [15:0] w, input bit fs_release, input string tag);
        int s0 = n_samp, x0 = n_sec;
        send_word(w, fs_release);
        settle();
        check(n_samp == s0 + 1, {tag, " R2 sample strobe count"}, n_samp - s0, 1);
        check(lat_sample == exp_sample(w), {tag, " R2 sample value"}, lat_sample, exp_sample(w));
        check(lat_cmd == exp_cmd(w), {tag, " R3 command code"}, lat_cmd, exp_cmd(w));
        check(n_sec == x0, {tag, " R6 no secondary strobe"}, n_sec - x0, 0);
    endtask

    task automatic do_secondary(input logic [15:0] s, input logic [15:0] prev_w, input string tag);
        int s0 = n_samp, x0 = n_sec;
        send_word(s, 1'b0);
        settle();
        check(n_sec == x0 + 1, {tag, " R5 secondary strobe count"}, n_sec - x0, 1);
        check(lat_sec == s, {tag, " R4 R5 secondary word"}, lat_sec, s);
        check(n_samp == s0, {tag, " R5 no sample strobe"}, n_samp - s0, 0);
        check(sample_o == exp_sample(prev_w), {tag, " R5 sample kept"}, sample_o, exp_sample(prev_w));
        check(cmd_o == exp_cmd(prev_w), {tag, " R5 command kept"}, cmd_o, exp_cmd(prev_w));
    endtask

    task automatic finish_run();
        check(strobe_err == 0, "R9 strobe shape", strobe_err, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] w, s;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(sample_o == 0 && cmd_o == 0 && sec_word_o == 0, "R8 reset outputs",
              {sample_o, cmd_o, sec_word_o}, 0);
        check(!sample_vld_o && !cmd_vld_o && !sec_vld_o, "R8 reset strobes",
              {sample_vld_o, cmd_vld_o, sec_vld_o}, 0);

        // R1 bit order with asymmetric patterns
        do_primary(16'h8001, 1'b0, "R1 msb-first a");
        do_primary(16'h1236, 1'b0, "R1 msb-first b");
        // R7 frame sync released after first bit
        do_primary(16'hA5A6, 1'b1, "R7 fs high mid-word");
        // R3 each code; R6 primary follows primary
        do_primary(16'hFFFC, 1'b0, "R3 code 00");
        do_primary(16'h0001, 1'b0, "R3 code 01");
        do_primary(16'h5552, 1'b1, "R3 code 10");

        // R4 frame sync low on all gap edges
        w = 16'h3C3F;
        do_primary(w, 1'b0, "R4 code 11");
        gap(4, 1);
        do_secondary(16'hC0DE, w, "R4 fs low in gap");
        do_primary(16'h7770, 1'b0, "R6 primary after secondary");

        // R4 extra idle edges after gap before secondary
        w = 16'h0F0B;
        do_primary(w, 1'b0, "R4 code 11 late");
        gap(6, 0);
        do_secondary(16'h8421, w, "R4 late secondary");

        // R8 reset mid-word, then the next word must be primary
        for (int i = 15; i >= 9; i--) shift_bit(1'b1, (i == 15) ? 1'b0 : 1'b1);
        fs_n = 1'b1;
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sample_o == 0 && cmd_o == 0, "R8 mid-word reset outputs", {sample_o, cmd_o}, 0);
        do_primary(16'h2468, 1'b0, "R8 after mid-word reset");

        // R8 reset while armed for a secondary word
        do_primary(16'h1113, 1'b0, "R8 code 11 before reset");
        gap(4, 0);
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        do_primary(16'hBEEC, 1'b0, "R8 armed state dropped");

        // constrained random mix
        for (int k = 0; k < 40; k++) begin
            w = 16'($urandom);
            do_primary(w, 1'($urandom), "R2 R3 random");
            if (w[1:0] == 2'b11) begin
                gap(4, 2);
                if ($urandom_range(0, 1) == 1) gap($urandom_range(1, 3), 0);
                s = 16'($urandom);
                do_secondary(s, w, "R4 R5 random");
            end
        end
        finish_run();
    end
endmodule